// File: doc/BRIEF.md
# Direct-Mapped Line Cache with Status-Bit Control

This block sits between a processor pipeline and a line-refill memory port. Loads are served from a direct-mapped array of 256 lines, four 32-bit words each. A hit returns the word one cycle after the request is accepted and does not stall. A miss starts a four-word refill. The block raises a global stall (`mem_wait`) that freezes every pipeline stage, and the processor keeps its request steady until the stall drops. Stores go straight through to memory. A store also updates the cached copy when the line is resident, but it never allocates a line.

Two control inputs stand in for two processor status bits. `cfg_enable` is bit 17 and `cfg_inval` is bit 16. With the enable bit low, every load refills, even a load that would hit. With the invalidate bit high, ordinary loads and stores become maintenance operations:
- A store still writes memory, and it also drops the line whose index equals the low byte of the store data.
- A load drops the line that its own address maps to, reads no memory and returns a don't-care word.

The address splits into three fields: tag is bits 31:12, index is bits 11:4, word offset is bits 3:2.

The controller has three states:
- LOOKUP is the idle state and serves hits, stores and invalidations. A load that must refill moves it to REFILL.
- REFILL requests words at offsets 3, 2, 1 and 0, one per `fill_ack`. The acknowledge of offset 0 moves it to REPLAY.
- REPLAY drops the stall for one cycle, so the held load completes from the fresh line. It then returns to LOOKUP.

Top module: `dm_cache`

## Requirements
- R1: After reset every line is invalid and `mem_wait`, `fill_req`, `rd_valid` and `wr_valid` are low, so the first load to any line refills.
- R2: With `cfg_enable`=1 and `cfg_inval`=0, a load whose line is valid and whose tag matches raises no stall and no refill, and it returns the stored word with `rd_valid` on the cycle after acceptance.
- R3: A load that must refill raises `mem_wait` combinationally in its first cycle. It then requests the four words of its line (tag and index of the load, offset in bits 3:2) in offset order 3, 2, 1, 0, and completes the load one cycle after the offset-0 word is accepted. With `fill_ack` high in every cycle, the stall lasts exactly 5 cycles.
- R4: With `cfg_enable`=0 and `cfg_inval`=0, every load refills its line, including repeated loads of a line that is already valid.
- R5: Stores never stall. In their accept cycle they drive `wr_valid` with the request address and data. A store to a resident line updates that word. A store to a non-resident line leaves the cached line in that index unchanged.
- R6: A load that follows a store to a resident line returns the stored data without a refill.
- R7: With `cfg_inval`=1 and `cfg_enable`=0, a store is still written through and invalidates the line whose index is `req_wdata[7:0]`. Other lines stay valid.
- R8: With `cfg_inval`=1 and `cfg_enable`=0, a load does not stall and issues no refill, and it invalidates the line indexed by its address bits 11:4.
- R9: With both control inputs at 1, the block behaves exactly as in R7 and R8.
- R10: The stall stays high while refill acknowledges are withheld, and the refill order and returned data are the same as without gaps.
- R11: A load whose index matches a resident line with a different tag refills and replaces that line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Cache enable (status bit 17) |
| cfg_inval | input | 1 | Line-invalidate mode (status bit 16) |
| req_valid | input | 1 | Processor access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address, word aligned |
| req_wdata | input | 32 | Store data |
| rd_valid | output | 1 | Load completed, data on `rd_data` |
| rd_data | output | 32 | Load result |
| mem_wait | output | 1 | Global pipeline stall |
| wr_valid | output | 1 | Write-through strobe |
| wr_addr | output | 32 | Write-through address |
| wr_data | output | 32 | Write-through data |
| fill_req | output | 1 | Refill word request |
| fill_addr | output | 32 | Address of requested refill word |
| fill_ack | input | 1 | Refill word returned this cycle |
| fill_data | input | 32 | Refill word |

## Verification
The bench targets the following corner cases, each with the failure a wrong design would show:
- **Refill order and length.** A wrong counter would fetch offsets ascending or skip a word, and would return stale or mixed data.
- **Disabled cache.** A design that ignored the enable bit would serve a resident line without refilling.
- **The two invalidate forms.** A store that used its address instead of its data byte would drop the wrong line. A load that refilled or stalled in invalidate mode would show refill traffic. The 11 setting is checked separately so that a design that treats it as normal operation is caught.
- **Store-then-load, index conflicts and slow refills.** A store that allocated, or a store that failed to update a hit, shows up as an unexpected refill or wrong data. A design that let the stall drop during a refill gap is also caught.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_REFILL = 2'd1,
        ST_REPLAY = 2'd2
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (set_en) valid_q[set_idx] <= 1'b1;
            if (inv_en) valid_q[inv_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) tag_q[set_idx] <= set_tag;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int IDX_W  = 8,
    parameter int OFS_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [IDX_W+OFS_W-1:0] waddr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [IDX_W+OFS_W-1:0] raddr,
    output logic [DATA_W-1:0]      rdata
);
    localparam int ENTRIES = 1 << (IDX_W + OFS_W);

    logic [DATA_W-1:0] word_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) word_q[waddr] <= wdata;
    end

    assign rdata = word_q[raddr];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             cfg_enable,
    input  logic             cfg_inval,
    input  logic             line_hit,
    input  logic             fill_ack,
    output logic             mem_wait,
    output logic             fill_req,
    output logic             fill_last,
    output logic             in_lookup,
    output logic [OFS_W-1:0] word_cnt
);
    dmc_state_e state_q, state_d;
    logic       need_fill;

    assign need_fill = req_valid && !req_write && !cfg_inval
                       && !(cfg_enable && line_hit);
    assign fill_last = (word_cnt == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    // refill word counter, counts down from the top offset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  word_cnt <= '1;
        else if (state_q == ST_REFILL && fill_ack)   word_cnt <= word_cnt - 1'b1;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        mem_wait  = 1'b0;
        fill_req  = 1'b0;
        in_lookup = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                in_lookup = 1'b1;
                mem_wait  = need_fill;
                if (need_fill) state_d = ST_REFILL;
            end
            ST_REFILL: begin
                mem_wait = 1'b1;
                fill_req = 1'b1;
                if (fill_ack && fill_last) state_d = ST_REPLAY;
            end
            ST_REPLAY: begin
                state_d = ST_LOOKUP;
            end
            default: state_d = ST_LOOKUP;
        endcase
    end
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_inval,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_wait,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_ack,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int TAG_W  = ADDR_W - IDX_W - OFS_W - BYTE_W;

    logic [IDX_W-1:0] idx;
    logic [OFS_W-1:0] word;
    logic [TAG_W-1:0] tag;
    logic             tag_valid;
    logic [TAG_W-1:0] tag_rd;
    logic             line_hit;
    logic             fill_last;
    logic             in_lookup;
    logic [OFS_W-1:0] word_cnt;
    logic             accept;
    logic             store_go;
    logic             fill_we;
    logic             d_we;
    logic [IDX_W+OFS_W-1:0] d_waddr;
    logic [DATA_W-1:0]      d_wdata;
    logic [DATA_W-1:0]      d_rdata;
    logic             inv_en;
    logic [IDX_W-1:0] inv_idx;

    assign word = req_addr[BYTE_W +: OFS_W];
    assign idx  = req_addr[BYTE_W+OFS_W +: IDX_W];
    assign tag  = req_addr[ADDR_W-1 -: TAG_W];

    assign line_hit = tag_valid && (tag_rd == tag);
    assign accept   = req_valid && !mem_wait;
    assign store_go = accept && req_write && in_lookup;

    dmc_ctrl #(.OFS_W(OFS_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .cfg_enable(cfg_enable),
        .cfg_inval (cfg_inval),
        .line_hit  (line_hit),
        .fill_ack  (fill_ack),
        .mem_wait  (mem_wait),
        .fill_req  (fill_req),
        .fill_last (fill_last),
        .in_lookup (in_lookup),
        .word_cnt  (word_cnt)
    );

    // refill and store-hit share the single array write port
    assign fill_we = fill_req && fill_ack;
    assign d_we    = fill_we || (store_go && line_hit);
    assign d_waddr = fill_we ? {idx, word_cnt} : {idx, word};
    assign d_wdata = fill_we ? fill_data : req_wdata;

    // invalidation: store drops the line named by its data, load its own line
    assign inv_en  = accept && in_lookup && cfg_inval;
    assign inv_idx = req_write ? req_wdata[IDX_W-1:0] : idx;

    dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (idx),
        .rd_valid(tag_valid),
        .rd_tag  (tag_rd),
        .set_en  (fill_we && fill_last),
        .set_idx (idx),
        .set_tag (tag),
        .inv_en  (inv_en),
        .inv_idx (inv_idx)
    );

    dmc_data_store #(.IDX_W(IDX_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) data_i (
        .clk  (clk),
        .we   (d_we),
        .waddr(d_waddr),
        .wdata(d_wdata),
        .raddr({idx, word}),
        .rdata(d_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= accept && !req_write;
            if (accept && !req_write) rd_data <= d_rdata;
        end
    end

    assign wr_valid  = store_go;
    assign wr_addr   = req_addr;
    assign wr_data   = req_wdata;
    assign fill_addr = {req_addr[ADDR_W-1:BYTE_W+OFS_W], word_cnt, {BYTE_W{1'b0}}};
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 2,
    parameter int BYTE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              cfg_inval,
    input logic              mem_wait,
    input logic              fill_req,
    input logic              fill_ack,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              rd_valid,
    input logic              wr_valid
);
    logic [OFS_W-1:0] fo;
    assign fo = fill_addr[BYTE_W +: OFS_W];

    // R3
    fill_first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_req) |-> (fo == '1));

    // R3
    fill_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_ack && fo != '0) |=> (fill_req && fo == OFS_W'($past(fo) - 1'b1)));

    // R5
    store_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !fill_req) |-> (!mem_wait && wr_valid));

    // R8
    inval_load_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && cfg_inval && !fill_req) |-> !mem_wait);

    // R10
    fill_only_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> mem_wait);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wait && req_valid) |=> $stable(req_addr));

    // R2
    rd_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write && !mem_wait));
endmodule

bind dm_cache dmc_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .BYTE_W(BYTE_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .cfg_inval(cfg_inval),
    .mem_wait (mem_wait),
    .fill_req (fill_req),
    .fill_ack (fill_ack),
    .fill_addr(fill_addr),
    .rd_valid (rd_valid),
    .wr_valid (wr_valid)
);

// File: tb/dm_cache_tb_top.sv
module dm_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b1, cfg_inval = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        rd_valid, mem_wait, wr_valid, fill_req;
    logic [31:0] rd_data, wr_addr, wr_data, fill_addr;
    logic        fill_ack = 1'b0;
    logic [31:0] fill_data = '0;

    int checks = 0;
    int errors = 0;
    int fill_words = 0;
    int line_err = 0;
    bit gap_mode = 0;
    bit phase = 0;
    logic [1:0]  order_q[$];
    logic [31:0] mem_m [logic [29:0]];

    always #5 clk = ~clk;

    dm_cache dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_inval(cfg_inval),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_wait(mem_wait), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_ack(fill_ack), .fill_data(fill_data)
    );

    function automatic logic [31:0] model_rd(input logic [31:0] a);
        if (mem_m.exists(a[31:2])) return mem_m[a[31:2]];
        return a ^ 32'h5A00_00C3;
    endfunction

    // refill responder, drives on the falling edge
    logic [31:0] cur_line = '0;
    always @(negedge clk) begin
        if (rst_n && fill_req && !(gap_mode && !phase)) begin
            fill_ack  = 1'b1;
            fill_data = model_rd(fill_addr);
            order_q.push_back(fill_addr[3:2]);
            if (fill_addr[31:4] != cur_line[31:4] || fill_addr[1:0] != 2'b00) line_err++;
            fill_words++;
            phase = 1'b0;
        end else begin
            fill_ack = 1'b0;
            phase = fill_req;
        end
    end

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rdata, output int stalls, output int fills,
                          output logic got_rd, output logic got_wr);
        int f0;
        f0 = fill_words;
        order_q.delete();
        line_err = 0;
        cur_line = a;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        stalls = 0;
        #1;
        while (mem_wait) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        got_wr = wr_valid;
        if (wr) begin
            chk("R5", "wr_addr", wr_addr, a);
            chk("R5", "wr_data", wr_data, d);
            mem_m[a[31:2]] = d;
        end
        @(posedge clk);
        #1;
        got_rd = rd_valid;
        rdata  = rd_data;
        req_valid = 1'b0;
        fills = fill_words - f0;
    endtask

    task automatic load_expect(input string rq, input logic [31:0] a, input int exp_fills);
        logic [31:0] rd; int st, fl; logic gr, gw;
        access(1'b0, a, 32'h0, rd, st, fl, gr, gw);
        chk(rq, "refill words", 32'(fl), 32'(exp_fills));
        chk(rq, "rd_valid", {31'b0, gr}, 32'd1);
        chk(rq, "load data", rd, model_rd(a));
        if (exp_fills == 0) chk(rq, "stall cycles", 32'(st), 32'd0);
        else if (!gap_mode) chk(rq, "stall cycles", 32'(st), 32'd5);
        if (exp_fills == 4) begin
            chk(rq, "refill order", {order_q[0], order_q[1], order_q[2], order_q[3]}, 32'h000000E4);
            chk(rq, "refill line addr errors", 32'(line_err), 32'd0);
        end
    endtask

    task automatic store_expect(input string rq, input logic [31:0] a, input logic [31:0] d);
        logic [31:0] rd; int st, fl; logic gr, gw;
        access(1'b1, a, d, rd, st, fl, gr, gw);
        chk(rq, "store stall", 32'(st), 32'd0);
        chk(rq, "store write-through", {31'b0, gw}, 32'd1);
        chk(rq, "store refill", 32'(fl), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1", "mem_wait", {31'b0, mem_wait}, 32'd0);
        chk("R1", "fill_req", {31'b0, fill_req}, 32'd0);
        chk("R1", "rd_valid", {31'b0, rd_valid}, 32'd0);
        chk("R1", "wr_valid", {31'b0, wr_valid}, 32'd0);
    endtask

    task automatic t_miss_and_hit;
        load_expect("R1", 32'h0000_1230, 4);   // R3 order and 5-cycle stall
        load_expect("R2", 32'h0000_1234, 0);
        load_expect("R2", 32'h0000_123C, 0);
    endtask

    task automatic t_disabled;
        cfg_enable = 1'b0;
        load_expect("R4", 32'h0000_1234, 4);
        load_expect("R4", 32'h0000_1234, 4);
        cfg_enable = 1'b1;
        load_expect("R4", 32'h0000_1238, 0);
    endtask

    task automatic t_store;
        store_expect("R5", 32'h0000_1238, 32'hDEAD_BEEF);
        load_expect("R6", 32'h0000_1238, 0);
        store_expect("R5", 32'h0005_5230, 32'h0BAD_F00D);
        load_expect("R5", 32'h0000_1230, 0);
    endtask

    task automatic t_conflict;
        load_expect("R11", 32'h0005_5234, 4);
        load_expect("R11", 32'h0005_5230, 0);
        load_expect("R11", 32'h0000_1238, 4);
    endtask

    task automatic t_inval_store;
        load_expect("R7", 32'h0000_2470, 4);
        load_expect("R7", 32'h0000_2480, 4);
        cfg_enable = 1'b0; cfg_inval = 1'b1;
        store_expect("R7", 32'h0000_9000, 32'h1234_5647);
        cfg_enable = 1'b1; cfg_inval = 1'b0;
        load_expect("R7", 32'h0000_2480, 0);
        load_expect("R7", 32'h0000_2474, 4);
    endtask

    task automatic t_inval_load(input logic en, input string rq);
        logic [31:0] rd; int st, fl; logic gr, gw;
        load_expect(rq, 32'h0000_2484, 0);
        cfg_enable = en; cfg_inval = 1'b1;
        access(1'b0, 32'h0000_2484, 32'h0, rd, st, fl, gr, gw);
        chk(rq, "inval load stall", 32'(st), 32'd0);
        chk(rq, "inval load refill", 32'(fl), 32'd0);
        chk(rq, "inval load rd_valid", {31'b0, gr}, 32'd1);
        cfg_enable = 1'b1; cfg_inval = 1'b0;
        load_expect(rq, 32'h0000_2484, 4);
    endtask

    task automatic t_inval_store_11;
        load_expect("R9", 32'h0000_2470, 0);
        cfg_enable = 1'b1; cfg_inval = 1'b1;
        store_expect("R9", 32'h0000_9004, 32'h0000_0048);
        cfg_enable = 1'b1; cfg_inval = 1'b0;
        load_expect("R9", 32'h0000_2470, 0);
        load_expect("R9", 32'h0000_2488, 4);
    endtask

    task automatic t_slow_fill;
        logic [31:0] rd; int st, fl; logic gr, gw;
        gap_mode = 1'b1;
        access(1'b0, 32'h0000_3008, 32'h0, rd, st, fl, gr, gw);
        chk("R10", "refill words", 32'(fl), 32'd4);
        chk("R10", "stall longer than gapless", {31'b0, st > 5}, 32'd1);
        chk("R10", "refill order", {order_q[0], order_q[1], order_q[2], order_q[3]}, 32'h000000E4);
        chk("R10", "load data", rd, model_rd(32'h0000_3008));
        gap_mode = 1'b0;
        load_expect("R10", 32'h0000_300C, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_miss_and_hit();
        t_disabled();
        t_store();
        t_conflict();
        t_inval_store();
        t_inval_load(1'b0, "R8");
        t_inval_load(1'b1, "R9");
        t_inval_store_11();
        t_slow_fill();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule